// File: doc/BRIEF.md
# Three-Packet Payload Queue

This block stores up to three complete packets of 1 to 32 bytes for a short-range radio controller. The register interface fills and drains it one byte at a time. The radio datapath pushes and pops whole packets in a single cycle. The same module serves the transmit and receive directions. A parameter picks which layout the packed status byte uses.

A packet written from the host side stays staged until the host transaction ends, which is the chip-select rising. Only then does it become the newest entry. When the queue already holds three packets, a new packet evicts the oldest one, so the queue never stalls. A host read always begins at byte 0 of the oldest packet. That packet is removed when the read transaction ends, however many bytes were taken. A flush command clears the queue. A repeat mode keeps the oldest packet in place when the datapath reports it sent, so the same packet goes out again and again.

Top module: `pkt_fifo3`

## Requirements
- R1: After reset the queue is empty. `status_o` reads 0x10 with the transmit layout, `head_pipe_o` reads 3'b111 and `link_head_len_o` reads 0.
- R2: Host bytes are stored in order from byte 0. The packet is not visible until the cycle after `host_end`, and its length equals the number of bytes written in that transaction.
- R3: A packet pushed from either side while three packets are held evicts the oldest one. The queue then still holds three packets.
- R4: `host_rd_byte` shows byte `k` of the oldest packet after `k` read strobes in the current transaction. It shows 0 past the packet length or when the queue is empty.
- R5: A `host_end` after at least one read strobe, with no byte written, removes the oldest packet, even if fewer bytes were read than the packet holds.
- R6: `link_push_en` with a length of 1 to 32 stores the whole packet and its pipe number. A length of 0 or above 32 is ignored.
- R7: `link_pop_en` removes the oldest packet, unless repeat mode is on. In repeat mode the oldest packet stays unchanged.
- R8: Repeat mode is set by `host_reuse`. It is cleared by a flush or by a committed host write.
- R9: `host_flush` empties the queue. It overrides any host end or link push or pop in the same cycle.
- R10: With the transmit layout, `status_o` bit 6 is repeat mode, bit 5 is full (three packets) and bit 4 is empty. All other bits are 0. The receive layout puts full at bit 1 and empty at bit 0.
- R11: `head_pipe_o` gives the pipe number (0 to 5) of the oldest packet, or 3'b111 when empty. Host-written packets carry pipe 0.
- R12: Bytes written after the 32nd in one transaction are dropped. The packet length stays 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_wr_byte | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe, advances read index |
| host_rd_byte | output | 8 | Current read byte of oldest packet |
| host_end | input | 1 | End of host transaction (chip-select rise) |
| host_flush | input | 1 | Empty the queue |
| host_reuse | input | 1 | Enter repeat mode |
| link_push_en | input | 1 | Push a whole packet from the datapath |
| link_push_len | input | 6 | Length of pushed packet |
| link_push_pipe | input | 3 | Pipe number of pushed packet |
| link_push_data | input | 256 | Pushed packet, byte 0 in bits 7:0 |
| link_pop_en | input | 1 | Datapath finished sending the oldest packet |
| link_head_data | output | 256 | Oldest packet, byte 0 in bits 7:0 |
| link_head_len | output | 6 | Length of oldest packet, 0 when empty |
| head_pipe_o | output | 3 | Pipe of oldest packet, 3'b111 when empty |
| status_o | output | 8 | Packed full/empty/repeat status |

## Verification
The assertions assume that only one queue event per cycle carries meaning. Host byte strobes never coincide with `host_end`. A link pop is never raised together with a link push. The bench drives every host transaction as a run of strobes followed by a separate end pulse, and it serialises all other commands the same way. The single exception is a directed case that raises flush together with a push, to check the override rule. Random packet lengths, contents, pipes and read lengths cover partial reads, eviction when full, repeat mode and reads from an empty queue.

// File: rtl/pfifo_pkg.sv
// Shared types for the three-packet payload queue.
// Assumes: byte-wide host access, pipe numbers fit in three bits.
package pfifo_pkg;
    typedef logic [7:0] byte_t;
    typedef logic [2:0] pipe_t;
    localparam pipe_t PIPE_NONE = 3'b111;
endpackage

// File: rtl/pfifo_stage.sv
// Host-side byte staging: gathers written bytes into a packet image and
// tracks the read index into the oldest packet.
// Assumes: clear is pulsed at the end of every host transaction or flush.
module pfifo_stage #(
    parameter int MAX_BYTES = 32,
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  pfifo_pkg::byte_t       wr_byte,
    input  logic                   rd_en,
    input  logic                   clear,
    output logic [LEN_W-1:0]       wr_idx,
    output logic [LEN_W-1:0]       rd_idx,
    output logic [MAX_BYTES*8-1:0] stage_data
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BYTES);

    // Write index and staged image; bytes past the limit are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_idx     <= '0;
            stage_data <= '0;
        end else if (wr_en && (wr_idx < LIMIT)) begin
            stage_data[wr_idx*8 +: 8] <= wr_byte;
            wr_idx                    <= wr_idx + 1'b1;
        end
    end

    // Read index, saturating at the packet limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_idx <= '0;
        end else if (rd_en && (rd_idx < LIMIT)) begin
            rd_idx <= rd_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pfifo_ctrl.sv
// Slot bookkeeping: head index, occupancy and repeat flag.
// A push when full advances the head, evicting the oldest slot.
// Assumes: at most one of push/pop_host/pop_link/flush per cycle.
module pfifo_ctrl #(
    parameter int DEPTH = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop_host,
    input  logic             pop_link,
    input  logic             flush,
    input  logic             reuse_set,
    input  logic             reuse_clr,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             reuse
);
    localparam int SUM_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [IDX_W-1:0] head_next_slot;
    logic [SUM_W-1:0] tail_sum;
    logic             do_pop;

    // Wrapped successor of the head and the slot after the newest packet.
    always_comb begin
        head_next_slot = (head == IDX_W'(DEPTH - 1)) ? '0 : head + 1'b1;
        tail_sum       = SUM_W'(head) + SUM_W'(count);
        if (tail_sum >= SUM_W'(DEPTH)) begin
            tail = IDX_W'(tail_sum - SUM_W'(DEPTH));
        end else begin
            tail = IDX_W'(tail_sum);
        end
        do_pop = (pop_host || (pop_link && !reuse)) && (count != '0);
    end

    // Head and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            count <= '0;
        end else if (push) begin
            if (count == FULL_CNT) begin
                head <= head_next_slot;
            end else begin
                count <= count + 1'b1;
            end
        end else if (do_pop) begin
            head  <= head_next_slot;
            count <= count - 1'b1;
        end
    end

    // Repeat-mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || reuse_clr) begin
            reuse <= 1'b0;
        end else if (reuse_set) begin
            reuse <= 1'b1;
        end
    end
endmodule

// File: rtl/pfifo_store.sv
// Packet slot storage: payload image, length and pipe per slot,
// plus the byte selector for host reads of the head slot.
// Assumes: wr_len is already validated to 1..MAX_BYTES.
module pfifo_store #(
    parameter int DEPTH = 3,
    parameter int MAX_BYTES = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  logic [MAX_BYTES*8-1:0] wr_data,
    input  logic [LEN_W-1:0]       wr_len,
    input  pfifo_pkg::pipe_t       wr_pipe,
    input  logic [IDX_W-1:0]       rd_slot,
    input  logic [LEN_W-1:0]       rd_idx,
    output logic [MAX_BYTES*8-1:0] rd_data,
    output logic [LEN_W-1:0]       rd_len,
    output pfifo_pkg::pipe_t       rd_pipe,
    output pfifo_pkg::byte_t       rd_byte
);
    logic [MAX_BYTES*8-1:0] data_q [DEPTH];
    logic [LEN_W-1:0]       len_q  [DEPTH];
    pfifo_pkg::pipe_t       pipe_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // One slot: written whole when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[s] <= '0;
                len_q[s]  <= '0;
                pipe_q[s] <= '0;
            end else if (wr_en && (wr_slot == IDX_W'(s))) begin
                data_q[s] <= wr_data;
                len_q[s]  <= wr_len;
                pipe_q[s] <= wr_pipe;
            end
        end
    end

    // Head slot view and the byte at the host read index.
    always_comb begin
        rd_data = data_q[rd_slot];
        rd_len  = len_q[rd_slot];
        rd_pipe = pipe_q[rd_slot];
        rd_byte = '0;
        if (rd_idx < rd_len) begin
            rd_byte = rd_data[rd_idx*8 +: 8];
        end
    end
endmodule

// File: rtl/pkt_fifo3.sv
// Three-packet payload queue. Host side writes and reads bytes; the
// datapath side pushes and pops whole packets. New packets evict the
// oldest when full. Event priority: flush, host end, link push, link pop.
// Assumes: host byte strobes are not raised in the host_end cycle.
module pkt_fifo3 #(
    parameter int DEPTH = 3,
    parameter int MAX_BYTES = 32,
    parameter bit TX_SIDE = 1'b1,
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr_en,
    input  logic [7:0]             host_wr_byte,
    input  logic                   host_rd_en,
    output logic [7:0]             host_rd_byte,
    input  logic                   host_end,
    input  logic                   host_flush,
    input  logic                   host_reuse,
    input  logic                   link_push_en,
    input  logic [LEN_W-1:0]       link_push_len,
    input  logic [2:0]             link_push_pipe,
    input  logic [MAX_BYTES*8-1:0] link_push_data,
    input  logic                   link_pop_en,
    output logic [MAX_BYTES*8-1:0] link_head_data,
    output logic [LEN_W-1:0]       link_head_len,
    output logic [2:0]             head_pipe_o,
    output logic [7:0]             status_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [LEN_W-1:0]       wr_idx, rd_idx;
    logic [MAX_BYTES*8-1:0] stage_data;
    logic [IDX_W-1:0]       head, tail;
    logic [CNT_W-1:0]       count;
    logic                   reuse;
    logic                   ev_commit, ev_hpop, ev_lpush, ev_lpop, push_len_ok;
    logic                   q_empty, q_full;
    logic [MAX_BYTES*8-1:0] st_wdata, st_rdata;
    logic [LEN_W-1:0]       st_wlen, st_rlen;
    pfifo_pkg::pipe_t       st_wpipe, st_rpipe;
    pfifo_pkg::byte_t       st_rbyte;

    // Event decode with fixed priority.
    always_comb begin
        push_len_ok = (link_push_len != '0) && (link_push_len <= LEN_W'(MAX_BYTES));
        ev_commit   = !host_flush && host_end && (wr_idx != '0);
        ev_hpop     = !host_flush && host_end && (wr_idx == '0) && (rd_idx != '0);
        ev_lpush    = !host_flush && !host_end && link_push_en && push_len_ok;
        ev_lpop     = !host_flush && !host_end && !link_push_en && link_pop_en;
    end

    // Source select for slot writes.
    always_comb begin
        if (ev_commit) begin
            st_wdata = stage_data;
            st_wlen  = wr_idx;
            st_wpipe = '0;
        end else begin
            st_wdata = link_push_data;
            st_wlen  = link_push_len;
            st_wpipe = link_push_pipe;
        end
    end

    pfifo_stage #(.MAX_BYTES(MAX_BYTES)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en && !host_end),
        .wr_byte    (host_wr_byte),
        .rd_en      (host_rd_en && !host_end),
        .clear      (host_end || host_flush),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .stage_data (stage_data)
    );

    pfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev_commit || ev_lpush),
        .pop_host  (ev_hpop),
        .pop_link  (ev_lpop),
        .flush     (host_flush),
        .reuse_set (host_reuse && !host_flush && !ev_commit),
        .reuse_clr (ev_commit),
        .head      (head),
        .tail      (tail),
        .count     (count),
        .reuse     (reuse)
    );

    pfifo_store #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ev_commit || ev_lpush),
        .wr_slot (tail),
        .wr_data (st_wdata),
        .wr_len  (st_wlen),
        .wr_pipe (st_wpipe),
        .rd_slot (head),
        .rd_idx  (rd_idx),
        .rd_data (st_rdata),
        .rd_len  (st_rlen),
        .rd_pipe (st_rpipe),
        .rd_byte (st_rbyte)
    );

    // Head outputs, masked when the queue is empty.
    always_comb begin
        q_empty        = (count == '0);
        q_full         = (count == CNT_W'(DEPTH));
        link_head_data = q_empty ? '0 : st_rdata;
        link_head_len  = q_empty ? '0 : st_rlen;
        head_pipe_o    = q_empty ? pfifo_pkg::PIPE_NONE : st_rpipe;
        host_rd_byte   = q_empty ? '0 : st_rbyte;
    end

    // Status byte layout chosen by direction.
    if (TX_SIDE) begin : g_tx_status
        assign status_o = {1'b0, reuse, q_full, q_empty, 4'b0000};
    end else begin : g_rx_status
        assign status_o = {6'b000000, q_full, q_empty};
    end
endmodule

// File: rtl/pkt_fifo3_chk.sv
// Port-level property checker for the payload queue, bound to the top.
// Assumes: one meaningful queue event per cycle, as stated in the brief.
module pkt_fifo3_chk #(
    parameter bit TX_SIDE = 1'b1,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_end,
    input logic             host_flush,
    input logic             host_reuse,
    input logic             link_push_en,
    input logic [LEN_W-1:0] link_push_len,
    input logic             link_pop_en,
    input logic [LEN_W-1:0] link_head_len,
    input logic [2:0]       head_pipe_o,
    input logic [7:0]       status_o
);
    logic st_full, st_empty, st_reuse;
    assign st_full  = TX_SIDE ? status_o[5] : status_o[1];
    assign st_empty = TX_SIDE ? status_o[4] : status_o[0];
    assign st_reuse = TX_SIDE ? status_o[6] : 1'b0;

    // R11: empty queue reports no pipe
    a_r11_empty_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> (head_pipe_o == 3'b111 && link_head_len == '0));

    // R10: full and empty never together
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_full && st_empty));

    // R9: flush empties the queue next cycle
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        host_flush |=> st_empty);

    // R3: push into a full queue keeps it full
    a_r3_evict_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && link_push_en && !host_flush && !host_end &&
         link_push_len != '0 && link_push_len <= LEN_W'(32)) |=> st_full);

    // R7: pop in repeat mode leaves the head untouched
    a_r7_reuse_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (st_reuse && link_pop_en && !link_push_en && !host_flush && !host_end)
        |=> ($stable(link_head_len) && $stable(head_pipe_o)));

    // R8: reuse command sets the flag
    a_r8_reuse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (TX_SIDE && host_reuse && !host_flush && !host_end) |=> st_reuse);

    // R6: zero-length push changes nothing
    a_r6_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (link_push_en && link_push_len == '0 && !host_flush && !host_end && !host_reuse)
        |=> $stable(status_o));
endmodule

bind pkt_fifo3 pkt_fifo3_chk #(.TX_SIDE(TX_SIDE), .LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_end      (host_end),
    .host_flush    (host_flush),
    .host_reuse    (host_reuse),
    .link_push_en  (link_push_en),
    .link_push_len (link_push_len),
    .link_pop_en   (link_pop_en),
    .link_head_len (link_head_len),
    .head_pipe_o   (head_pipe_o),
    .status_o      (status_o)
);

// File: tb/pkt_fifo3_tb_top.sv
module pkt_fifo3_tb_top;
    localparam int MAXB = 32;
    localparam int LW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr_en = 0, host_rd_en = 0, host_end = 0;
    logic            host_flush = 0, host_reuse = 0;
    logic [7:0]      host_wr_byte = 0, host_rd_byte;
    logic            link_push_en = 0, link_pop_en = 0;
    logic [LW-1:0]   link_push_len = 0, link_head_len;
    logic [2:0]      link_push_pipe = 0, head_pipe_o;
    logic [MAXB*8-1:0] link_push_data = 0, link_head_data;
    logic [7:0]      status_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Reference model: index 0 is the oldest packet.
    logic [7:0] m_data [3][MAXB];
    int         m_len  [3];
    int         m_pipe [3];
    int         m_cnt = 0;
    bit         m_reuse = 0;
    logic [7:0] pkt [MAXB];

    always #2.5 clk = ~clk;

    pkt_fifo3 dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_byte(host_wr_byte),
        .host_rd_en(host_rd_en), .host_rd_byte(host_rd_byte),
        .host_end(host_end), .host_flush(host_flush), .host_reuse(host_reuse),
        .link_push_en(link_push_en), .link_push_len(link_push_len),
        .link_push_pipe(link_push_pipe), .link_push_data(link_push_data),
        .link_pop_en(link_pop_en), .link_head_data(link_head_data),
        .link_head_len(link_head_len), .head_pipe_o(head_pipe_o),
        .status_o(status_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_status();
        return (int'(m_reuse) << 6) | (int'(m_cnt == 3) << 5) | (int'(m_cnt == 0) << 4);
    endfunction

    function automatic int exp_pipe();
        return (m_cnt == 0) ? 7 : m_pipe[0];
    endfunction

    function automatic int exp_rd_byte(input int k);
        if (m_cnt == 0 || k >= m_len[0]) return 0;
        return int'(m_data[0][k]);
    endfunction

    task automatic m_push(input int len, input int pipe);
        if (m_cnt == 3) begin
            for (int s = 0; s < 2; s++) begin
                m_data[s] = m_data[s+1]; m_len[s] = m_len[s+1]; m_pipe[s] = m_pipe[s+1];
            end
            m_cnt = 2;
        end
        for (int i = 0; i < MAXB; i++) m_data[m_cnt][i] = (i < len) ? pkt[i] : 8'h00;
        m_len[m_cnt] = len;
        m_pipe[m_cnt] = pipe;
        m_cnt++;
    endtask

    task automatic m_pop();
        if (m_cnt > 0) begin
            for (int s = 0; s < 2; s++) begin
                m_data[s] = m_data[s+1]; m_len[s] = m_len[s+1]; m_pipe[s] = m_pipe[s+1];
            end
            m_cnt--;
        end
    endtask

    // Compare all visible state at a negedge.
    task automatic check_state(input string req);
        int bad;
        chk({req, " status"}, int'(status_o), exp_status());
        chk({req, " R11 pipe"}, int'(head_pipe_o), exp_pipe());
        chk({req, " head_len"}, int'(link_head_len), (m_cnt == 0) ? 0 : m_len[0]);
        bad = 0;
        if (m_cnt > 0)
            for (int i = 0; i < m_len[0]; i++)
                if (link_head_data[i*8 +: 8] != m_data[0][i]) bad++;
        chk({req, " head_data mismatches"}, bad, 0);
    endtask

    task automatic host_write(input int n, input bit check_hidden);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_wr_en = 1; host_wr_byte = pkt[i];
        end
        @(negedge clk);
        host_wr_en = 0;
        if (check_hidden) check_state("R2 before end");
        host_end = 1;
        @(negedge clk);
        host_end = 0;
        m_push((n > MAXB) ? MAXB : n, 0);
        m_reuse = 0;
    endtask

    task automatic host_read(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_rd_en = 0;
            chk("R4 read byte", int'(host_rd_byte), exp_rd_byte(i));
            host_rd_en = 1;
        end
        @(negedge clk);
        host_rd_en = 0; host_end = 1;
        @(negedge clk);
        host_end = 0;
        if (n > 0) m_pop();
    endtask

    task automatic link_push(input int len, input int pipe);
        @(negedge clk);
        link_push_en = 1; link_push_len = LW'(len); link_push_pipe = 3'(pipe);
        for (int i = 0; i < MAXB; i++) link_push_data[i*8 +: 8] = pkt[i];
        @(negedge clk);
        link_push_en = 0;
        if (len >= 1 && len <= MAXB) m_push(len, pipe);
    endtask

    task automatic link_pop();
        @(negedge clk);
        link_pop_en = 1;
        @(negedge clk);
        link_pop_en = 0;
        if (!m_reuse) m_pop();
    endtask

    task automatic pulse_flush();
        @(negedge clk); host_flush = 1;
        @(negedge clk); host_flush = 0;
        m_cnt = 0; m_reuse = 0;
    endtask

    task automatic pulse_reuse();
        @(negedge clk); host_reuse = 1;
        @(negedge clk); host_reuse = 0;
        m_reuse = 1;
    endtask

    task automatic fill_pkt();
        for (int i = 0; i < MAXB; i++) pkt[i] = 8'($urandom);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int op, len;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(status_o), 8'h10);
        chk("R1 pipe", int'(head_pipe_o), 7);
        chk("R1 len", int'(link_head_len), 0);

        // R2/R3: three host packets, then a fourth evicts the first
        for (int p = 0; p < 4; p++) begin
            fill_pkt();
            host_write(p + 3, p == 0);
            check_state("R2 R3 host fill");
        end
        chk("R3 still full", int'(status_o[5]), 1);

        // R5: short read pops whole packet
        host_read(1);
        check_state("R5 partial read pop");
        // R4: full read plus bytes past length read as zero
        host_read(m_len[0] + 2);
        check_state("R4 read past len");

        // R6: bad lengths ignored, then valid push with pipe
        fill_pkt();
        link_push(0, 2);
        check_state("R6 zero len");
        link_push(33, 2);
        check_state("R6 over len");
        link_push(9, 5);
        check_state("R6 push R11 pipe");
        link_push(32, 4);
        check_state("R6 push max");

        // R7/R8: repeat mode keeps head, host write clears it
        pulse_reuse();
        check_state("R8 reuse set");
        link_pop();
        link_pop();
        check_state("R7 reuse hold");
        fill_pkt();
        host_write(4, 0);
        check_state("R8 cleared by write");
        link_pop();
        check_state("R7 normal pop");

        // R12: overlong write truncated
        pulse_flush();
        fill_pkt();
        host_write(35, 0);
        check_state("R12 truncate");
        chk("R12 len", int'(link_head_len), 32);

        // R9: flush beats a simultaneous push
        @(negedge clk);
        host_flush = 1; link_push_en = 1; link_push_len = 6'd5; link_push_pipe = 3'd1;
        @(negedge clk);
        host_flush = 0; link_push_en = 0;
        m_cnt = 0; m_reuse = 0;
        check_state("R9 flush priority");
        // R4: read from empty gives zero
        host_read(2);
        check_state("R4 empty read");

        // Random mix
        for (int t = 0; t < 400; t++) begin
            op = int'($urandom_range(0, 9));
            fill_pkt();
            len = int'($urandom_range(1, 32));
            case (op)
                0, 1: host_write(len, 0);
                2, 3: link_push((($urandom_range(0, 15)) == 0) ? 0 : len, int'($urandom_range(0, 5)));
                4, 5: host_read(int'($urandom_range(1, 34)));
                6:    link_pop();
                7:    pulse_reuse();
                8:    if ($urandom_range(0, 3) == 0) pulse_flush(); else link_pop();
                default: host_read(int'($urandom_range(1, 4)));
            endcase
            check_state("R2 R3 R6 R7 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule